// File: doc/BRIEF.md
# NAND Host Cycle Sequencer

This block is the host side of a parallel NAND-style flash link. A request carries an opcode byte, an optional 27-bit location, a word count, a direction flag, a flag that marks the operation as modifying (program or erase) and a bus-width flag. The block turns each request into pin activity. First comes a latched opcode cycle. Next come four location cycles, when a location is present. Last come write-strobe pulses that carry outgoing words, or read-strobe pulses that fetch incoming words.

Strobe low and high times are counted in system clocks and come from two configuration inputs. Any setting below two clocks is raised to two. Outgoing words are pulled from the host one at a time through a valid/ready pair. Incoming words are captured on the rising edge of the read strobe and offered to the host through a second valid/ready pair. The chip select is released whenever no request is in flight, which puts the device in standby. A single-cycle `done` marks the end of every request.

Top module: `nseq_engine`

## Requirements
- R1: While no request is in flight, `req_ready`=1, `ce_n`=1, `we_n`=1, `re_n`=1, `cle`=0, `ale`=0 and `io_oe`=0. This is also the state right after reset.
- R2: Every request starts with exactly one `we_n` low pulse. During that pulse `cle`=1, `ale`=0, `ce_n`=0 and `re_n`=1, and `io_out` carries {8'h00, `req_cmd`}.
- R3: When `req_has_addr`=1, exactly four `we_n` pulses follow the opcode, each with `ale`=1, `cle`=0, `ce_n`=0 and `re_n`=1. They carry `req_addr` bits 7:0, then 15:8, then 23:16, then {5'b0, bits 26:24}, with `io_out[15:8]`=0 in every one. When `req_has_addr`=0, no location cycle is sent.
- R4: For a write request (`req_read`=0) with `req_len`=N, N further `we_n` pulses follow, with `cle`=`ale`=0 and `io_oe`=1. Pulse k carries the k-th word accepted on `wr_valid`/`wr_ready`. In narrow mode (`req_wide`=0) bits 15:8 of that word are driven as 0.
- R5: For a read request with `req_len`=N, exactly N `re_n` low pulses follow. During each one `we_n`=1, `cle`=`ale`=0 and `io_oe`=0.
- R6: Each read word is the value of `io_in` at the clock edge where `re_n` rises, with bits 15:8 forced to 0 in narrow mode. It is offered on `rd_valid`/`rd_data` until `rd_ready`. The next `re_n` pulse does not start before that hand-off.
- R7: Every `we_n` or `re_n` low pulse lasts max(2, `cfg_lo`) clocks. Between two back-to-back location pulses, and between the opcode pulse and the first location pulse, `we_n` stays high for max(2, `cfg_hi`) clocks.
- R8: While `ce_n`=0, `wp_n` equals the request's `req_modify` and holds steady. While idle, `wp_n`=0.
- R9: After the last pulse of a request, `done` is high for exactly one cycle. The block is idle (R1) in the next cycle.
- R10: `we_n` and `re_n` are never low together, and `cle` and `ale` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_lo | input | 4 | Strobe low time in clocks (minimum 2 applied) |
| cfg_hi | input | 4 | Strobe high time in clocks (minimum 2 applied) |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted (block idle) |
| req_cmd | input | 8 | Opcode byte |
| req_addr | input | 27 | Location sent in four cycles |
| req_has_addr | input | 1 | Send location cycles |
| req_len | input | 8 | Number of data words |
| req_read | input | 1 | 1 = fetch words, 0 = send words |
| req_modify | input | 1 | Program/erase request: hold `wp_n` high |
| req_wide | input | 1 | 1 = 16-bit data words, 0 = 8-bit |
| wr_valid | input | 1 | Outgoing word available |
| wr_ready | output | 1 | Outgoing word taken |
| wr_data | input | 16 | Outgoing word |
| rd_valid | output | 1 | Incoming word available |
| rd_ready | input | 1 | Host takes incoming word |
| rd_data | output | 16 | Incoming word |
| done | output | 1 | One-cycle end-of-request pulse |
| ce_n | output | 1 | Chip select, active low |
| cle | output | 1 | Opcode latch enable |
| ale | output | 1 | Location latch enable |
| we_n | output | 1 | Write strobe, active low |
| re_n | output | 1 | Read strobe, active low |
| wp_n | output | 1 | Write protect, active low |
| io_out | output | 16 | Bus value driven |
| io_oe | output | 1 | Bus driver enable |
| io_in | input | 16 | Bus value from device |

## Verification
One pulse can end in the same cycle as the next one starts. The strobe timer's last high cycle can restart it for the opcode-to-location and location-to-location steps, with no idle cycle between them. The bench provokes this on every request that carries a location, under several low and high settings, including settings below the two-clock floor. It measures each `we_n` high stretch that ends in a location pulse and compares it with max(2, `cfg_hi`). Each latched byte must also match the opcode and location slices, so a lost or doubled pulse at that hand-over shows up.

// File: rtl/nseq_pkg.sv
package nseq_pkg;
    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_CMD   = 3'd1,
        S_ADDR  = 3'd2,
        S_WWAIT = 3'd3,
        S_WDATA = 3'd4,
        S_RDATA = 3'd5,
        S_RHOLD = 3'd6,
        S_DONE  = 3'd7
    } nseq_state_e;
endpackage

// File: rtl/nseq_strobe_timer.sv
module nseq_strobe_timer #(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [TW-1:0] lo_i,
    input  logic [TW-1:0] hi_i,
    output logic          low_o,
    output logic          rise_o,
    output logic          fin_o
);
    typedef struct packed {
        logic          active;
        logic          phase;
        logic [TW-1:0] cnt;
    } tmr_t;

    tmr_t q, d;
    logic [TW-1:0] lo_eff, hi_eff;

    assign lo_eff = (lo_i < TW'(2)) ? TW'(2) : lo_i;
    assign hi_eff = (hi_i < TW'(2)) ? TW'(2) : hi_i;

    always_comb begin
        d = q;
        if (q.active) begin
            if (!q.phase) begin
                if (q.cnt == lo_eff - TW'(1)) begin
                    d.phase = 1'b1;
                    d.cnt   = '0;
                end else begin
                    d.cnt = q.cnt + TW'(1);
                end
            end else begin
                if (q.cnt == hi_eff - TW'(1)) begin
                    d.active = 1'b0;
                    d.cnt    = '0;
                end else begin
                    d.cnt = q.cnt + TW'(1);
                end
            end
        end
        if (start_i) begin
            d.active = 1'b1;
            d.phase  = 1'b0;
            d.cnt    = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign low_o  = q.active && !q.phase;
    assign rise_o = low_o && (q.cnt == lo_eff - TW'(1));
    assign fin_o  = q.active && q.phase && (q.cnt == hi_eff - TW'(1));
endmodule

// File: rtl/nseq_addr_slice.sv
module nseq_addr_slice #(
    parameter int ADDR_W = 27,
    parameter int NBYTES = 4,
    parameter int IDX_W  = 2
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic [7:0]        byte_o
);
    localparam int PAD = NBYTES * 8 - ADDR_W;
    logic [NBYTES*8-1:0] padded;

    generate
        if (PAD > 0) begin : g_pad
            assign padded = {{PAD{1'b0}}, addr_i};
        end else begin : g_nopad
            assign padded = addr_i;
        end
    endgenerate

    assign byte_o = padded[idx_i*8 +: 8];
endmodule

// File: rtl/nseq_engine.sv
module nseq_engine
    import nseq_pkg::*;
#(
    parameter int ADDR_W = 27,
    parameter int LEN_W  = 8,
    parameter int TW     = 4,
    parameter int IO_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TW-1:0]     cfg_lo,
    input  logic [TW-1:0]     cfg_hi,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [7:0]        req_cmd,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_has_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              req_read,
    input  logic              req_modify,
    input  logic              req_wide,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [IO_W-1:0]   wr_data,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic [IO_W-1:0]   rd_data,
    output logic              done,
    output logic              ce_n,
    output logic              cle,
    output logic              ale,
    output logic              we_n,
    output logic              re_n,
    output logic              wp_n,
    output logic [IO_W-1:0]   io_out,
    output logic              io_oe,
    input  logic [IO_W-1:0]   io_in
);
    localparam int ABYTES = (ADDR_W + 7) / 8;
    localparam int IDX_W  = $clog2(ABYTES);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ABYTES - 1);

    typedef struct packed {
        nseq_state_e       state;
        logic [7:0]        cmd;
        logic [ADDR_W-1:0] addr;
        logic              has_addr;
        logic              rd;
        logic              modify;
        logic              wide;
        logic [LEN_W-1:0]  left;
        logic [IDX_W-1:0]  idx;
        logic [IO_W-1:0]   wbuf;
        logic [IO_W-1:0]   rbuf;
    } ctx_t;

    ctx_t q, d;
    logic t_start, t_low, t_rise, t_fin;
    logic [7:0] abyte;

    nseq_strobe_timer #(.TW(TW)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(t_start),
        .lo_i   (cfg_lo),
        .hi_i   (cfg_hi),
        .low_o  (t_low),
        .rise_o (t_rise),
        .fin_o  (t_fin)
    );

    nseq_addr_slice #(.ADDR_W(ADDR_W), .NBYTES(ABYTES), .IDX_W(IDX_W)) u_slice (
        .addr_i(q.addr),
        .idx_i (q.idx),
        .byte_o(abyte)
    );

    function automatic logic [IO_W-1:0] narrow(input logic [IO_W-1:0] w, input logic wide);
        return wide ? w : {{(IO_W-8){1'b0}}, w[7:0]};
    endfunction

    always_comb begin
        d         = q;
        t_start   = 1'b0;
        req_ready = 1'b0;
        wr_ready  = 1'b0;
        rd_valid  = 1'b0;
        done      = 1'b0;
        case (q.state)
            S_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    d.cmd      = req_cmd;
                    d.addr     = req_addr;
                    d.has_addr = req_has_addr;
                    d.rd       = req_read;
                    d.modify   = req_modify;
                    d.wide     = req_wide;
                    d.left     = req_len;
                    d.idx      = '0;
                    d.state    = S_CMD;
                    t_start    = 1'b1;
                end
            end
            S_CMD, S_ADDR: begin
                if (t_fin) begin
                    if (q.state == S_CMD && q.has_addr) begin
                        d.state = S_ADDR;
                        d.idx   = '0;
                        t_start = 1'b1;
                    end else if (q.state == S_ADDR && q.idx != LAST_IDX) begin
                        d.idx   = q.idx + IDX_W'(1);
                        t_start = 1'b1;
                    end else if (q.left == '0) begin
                        d.state = S_DONE;
                    end else if (q.rd) begin
                        d.state = S_RDATA;
                        t_start = 1'b1;
                    end else begin
                        d.state = S_WWAIT;
                    end
                end
            end
            S_WWAIT: begin
                wr_ready = 1'b1;
                if (wr_valid) begin
                    d.wbuf  = narrow(wr_data, q.wide);
                    d.state = S_WDATA;
                    t_start = 1'b1;
                end
            end
            S_WDATA: begin
                if (t_fin) begin
                    d.left  = q.left - LEN_W'(1);
                    d.state = (q.left == LEN_W'(1)) ? S_DONE : S_WWAIT;
                end
            end
            S_RDATA: begin
                if (t_rise) d.rbuf = narrow(io_in, q.wide);
                if (t_fin) begin
                    d.left  = q.left - LEN_W'(1);
                    d.state = S_RHOLD;
                end
            end
            S_RHOLD: begin
                rd_valid = 1'b1;
                if (rd_ready) begin
                    if (q.left == '0) begin
                        d.state = S_DONE;
                    end else begin
                        d.state = S_RDATA;
                        t_start = 1'b1;
                    end
                end
            end
            S_DONE: begin
                done    = 1'b1;
                d.state = S_IDLE;
            end
            default: d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        io_out = '0;
        case (q.state)
            S_CMD:   io_out = {{(IO_W-8){1'b0}}, q.cmd};
            S_ADDR:  io_out = {{(IO_W-8){1'b0}}, abyte};
            S_WDATA: io_out = q.wbuf;
            default: io_out = '0;
        endcase
    end

    assign io_oe   = (q.state == S_CMD) || (q.state == S_ADDR) || (q.state == S_WDATA);
    assign ce_n    = (q.state == S_IDLE);
    assign cle     = (q.state == S_CMD);
    assign ale     = (q.state == S_ADDR);
    assign we_n    = !(t_low && io_oe);
    assign re_n    = !(t_low && (q.state == S_RDATA));
    assign wp_n    = (q.state != S_IDLE) && q.modify;
    assign rd_data = q.rbuf;
endmodule

// File: rtl/nseq_engine_chk.sv
module nseq_engine_chk #(
    parameter int IO_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_ready,
    input logic            done,
    input logic            ce_n,
    input logic            cle,
    input logic            ale,
    input logic            we_n,
    input logic            re_n,
    input logic            wp_n,
    input logic [IO_W-1:0] io_out,
    input logic            io_oe
);
    AST_IDLE_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (ce_n && we_n && re_n && !cle && !ale && !io_oe)); // R1
    AST_CMD_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
        cle |-> (!ce_n && !ale && re_n && io_oe)); // R2
    AST_LATCH_HIGH_BYTE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (io_oe && (cle || ale)) |-> (io_out[IO_W-1:8] == '0)); // R3
    AST_READ_BUS_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !re_n |-> (!io_oe && we_n && !cle && !ale)); // R5
    AST_WE_MIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(we_n) |=> !we_n); // R7
    AST_RE_MIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(re_n) |=> !re_n); // R7
    AST_WP_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && $past(!ce_n)) |-> $stable(wp_n)); // R8
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready)); // R9
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !re_n)); // R10
    AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(cle && ale)); // R10
endmodule

bind nseq_engine nseq_engine_chk #(.IO_W(IO_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_ready(req_ready),
    .done     (done),
    .ce_n     (ce_n),
    .cle      (cle),
    .ale      (ale),
    .we_n     (we_n),
    .re_n     (re_n),
    .wp_n     (wp_n),
    .io_out   (io_out),
    .io_oe    (io_oe)
);

// File: tb/nseq_engine_bench.sv
`timescale 1ns/1ps
module nseq_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cfg_lo = 4'd2, cfg_hi = 4'd2;
    logic        req_valid = 1'b0, req_ready;
    logic [7:0]  req_cmd = '0;
    logic [26:0] req_addr = '0;
    logic        req_has_addr = 1'b0;
    logic [7:0]  req_len = '0;
    logic        req_read = 1'b0, req_modify = 1'b0, req_wide = 1'b0;
    logic        wr_valid = 1'b0, wr_ready;
    logic [15:0] wr_data = '0;
    logic        rd_valid, rd_ready = 1'b0;
    logic [15:0] rd_data;
    logic        done, ce_n, cle, ale, we_n, re_n, wp_n, io_oe;
    logic [15:0] io_out;
    logic [15:0] io_in = '0;

    always #2 clk = ~clk;

    nseq_engine u_nseq_engine (
        .clk(clk), .rst_n(rst_n), .cfg_lo(cfg_lo), .cfg_hi(cfg_hi),
        .req_valid(req_valid), .req_ready(req_ready), .req_cmd(req_cmd),
        .req_addr(req_addr), .req_has_addr(req_has_addr), .req_len(req_len),
        .req_read(req_read), .req_modify(req_modify), .req_wide(req_wide),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
        .done(done), .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n),
        .re_n(re_n), .wp_n(wp_n), .io_out(io_out), .io_oe(io_oe), .io_in(io_in)
    );

    int n_vec = 0, n_bad = 0;
    int lo_eff = 2, hi_eff = 2;
    bit cur_mod = 0;
    logic [15:0] seedtx = '0;
    logic [15:0] wdat [64];
    logic [15:0] rcap [64];
    int   ev_kind [128];
    logic [15:0] ev_word [128];
    int ev_n = 0, wptr = 0, rptr = 0, rd_issue = 0, done_cnt = 0;
    bit mon_on = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] pat(input int k);
        return 16'h3C5A ^ (16'(k) * 16'h0B17 + seedtx);
    endfunction

    // pin monitor and host model, all at the falling edge
    initial begin
        bit prev_we = 1, prev_re = 1, w_hs = 0;
        int we_lo = 0, we_hi = 0, re_lo = 0;
        logic l_cle = 0, l_ale = 0, l_oe = 0;
        logic [15:0] l_io = '0;
        forever begin
            @(negedge clk);
            if (!mon_on) continue;
            if (w_hs) wptr++;
            wr_valid = ($urandom % 4) != 0;
            wr_data  = wdat[wptr % 64];
            w_hs     = wr_valid && wr_ready;
            rd_ready = ($urandom % 3) != 0;
            if (rd_valid && rd_ready) begin
                rcap[rptr % 64] = rd_data;
                rptr++;
            end
            if (done) done_cnt++;
            if (!ce_n) chk(wp_n == cur_mod, "R8", "wp_n while selected", wp_n, cur_mod);
            if (!we_n) begin
                if (prev_we) begin
                    if (ale) chk(we_hi == hi_eff, "R7", "we_n high width", we_hi, hi_eff);
                    we_lo = 0;
                end
                we_lo++;
                l_cle = cle; l_ale = ale; l_io = io_out; l_oe = io_oe;
                chk(!ce_n && re_n, "R2", "ce_n/re_n during write strobe", {ce_n, re_n}, 2'b01);
            end else begin
                if (!prev_we) begin
                    chk(we_lo == lo_eff, "R7", "we_n low width", we_lo, lo_eff);
                    chk(l_oe, "R4", "bus driven during write strobe", l_oe, 1);
                    if (ev_n < 128) begin
                        ev_kind[ev_n] = l_cle ? 1 : (l_ale ? 2 : 0);
                        ev_word[ev_n] = l_io;
                    end
                    ev_n++;
                    we_hi = 0;
                end
                we_hi++;
            end
            if (!re_n) begin
                if (prev_re) begin
                    io_in = pat(rd_issue);
                    rd_issue++;
                    re_lo = 0;
                end
                re_lo++;
                chk(we_n && !cle && !ale && !io_oe, "R5", "levels during read strobe",
                    {we_n, cle, ale, io_oe}, 4'b1000);
            end else if (!prev_re) begin
                chk(re_lo == lo_eff, "R7", "re_n low width", re_lo, lo_eff);
            end
            prev_we = we_n;
            prev_re = re_n;
        end
    end

    task automatic run(input logic [7:0] c, input logic [26:0] a, input bit ha,
                       input int len, input bit rd, input bit md, input bit wide,
                       input int lo, input int hi);
        int t = 0;
        int n_exp;
        @(negedge clk);
        cfg_lo = 4'(lo); cfg_hi = 4'(hi);
        lo_eff = (lo < 2) ? 2 : lo;
        hi_eff = (hi < 2) ? 2 : hi;
        cur_mod = md;
        seedtx = 16'($urandom);
        for (int i = 0; i < 64; i++) wdat[i] = 16'($urandom);
        wptr = 0; rptr = 0; rd_issue = 0; ev_n = 0; done_cnt = 0;
        req_cmd = c; req_addr = a; req_has_addr = ha; req_len = 8'(len);
        req_read = rd; req_modify = md; req_wide = wide; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (done_cnt == 0 && t < 5000) begin
            @(negedge clk);
            t++;
        end
        chk(t < 5000, "R9", "done reached", t, 0);
        repeat (2) @(negedge clk);
        chk(done_cnt == 1, "R9", "done pulse count", done_cnt, 1);
        chk(req_ready && ce_n && we_n && re_n && !io_oe && !wp_n, "R1", "idle after request",
            {req_ready, ce_n, we_n, re_n, io_oe, wp_n}, 6'b111100);
        n_exp = 1 + (ha ? 4 : 0) + (rd ? 0 : len);
        chk(ev_n == n_exp, ha ? "R3" : "R2", "write strobe count", ev_n, n_exp);
        if (ev_n == n_exp) begin
            chk(ev_kind[0] == 1 && ev_word[0] == {8'h00, c}, "R2", "opcode cycle",
                {ev_kind[0], ev_word[0]}, {32'd1, 8'h00, c});
            for (int i = 0; i < 4; i++) begin
                if (ha) begin
                    logic [15:0] eb = {8'h00, 8'(a >> (8 * i))};
                    chk(ev_kind[1+i] == 2 && ev_word[1+i] == eb, "R3", "location cycle",
                        {ev_kind[1+i], ev_word[1+i]}, {32'd2, eb});
                end
            end
            for (int i = 0; i < len; i++) begin
                if (!rd) begin
                    int k = 1 + (ha ? 4 : 0) + i;
                    logic [15:0] ew = wide ? wdat[i] : {8'h00, wdat[i][7:0]};
                    chk(ev_kind[k] == 0 && ev_word[k] == ew, "R4", "data-in word",
                        {ev_kind[k], ev_word[k]}, {32'd0, ew});
                end
            end
        end
        if (rd) begin
            chk(rd_issue == len, "R5", "read strobe count", rd_issue, len);
            chk(rptr == len, "R6", "words handed to host", rptr, len);
            for (int i = 0; i < len && i < rptr; i++) begin
                logic [15:0] ew = wide ? pat(i) : {8'h00, pat(i)[7:0]};
                chk(rcap[i] == ew, "R6", "data-out word", rcap[i], ew);
            end
        end else begin
            chk(rd_issue == 0, "R5", "no read strobe on write", rd_issue, 0);
        end
    endtask

    initial begin
        int wd = 0;
        forever begin
            @(posedge clk);
            wd++;
            if (wd > 190000) begin
                n_vec++; n_bad++;
                $display("FAIL watchdog expired actual=%0d expected=<190000", wd);
                $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'h5EED));
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk(req_ready && ce_n && we_n && re_n && !cle && !ale && !io_oe && !done, "R1",
            "reset state", {req_ready, ce_n, we_n, re_n, cle, ale, io_oe, done}, 8'b11110000);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && ce_n && we_n && re_n && !io_oe, "R1", "idle after reset",
            {req_ready, ce_n, we_n, re_n, io_oe}, 5'b11110);
        mon_on = 1;
        // directed corners
        run(8'h80, 27'h7FFFFFF, 1, 3, 0, 1, 0, 0, 1);   // R7 clamp, R3 top slice, R4 narrow
        run(8'h00, 27'h1234567, 1, 4, 1, 0, 1, 5, 3);   // R6 wide read
        run(8'hFF, 27'h0, 0, 0, 0, 0, 0, 2, 2);         // R2 opcode only, R9
        run(8'h60, 27'h0ABCDEF, 1, 0, 0, 1, 0, 3, 2);   // R8 modify with no data
        run(8'h90, 27'h0, 0, 2, 1, 0, 0, 2, 4);         // R5 narrow read, no location
        run(8'h85, 27'h5555555, 1, 1, 0, 1, 1, 15, 15); // R7 long widths
        for (int n = 0; n < 30; n++) begin
            run(8'($urandom), 27'($urandom), 1'($urandom), int'($urandom % 12),
                1'($urandom), 1'($urandom), 1'($urandom),
                int'($urandom % 7), int'($urandom % 7));
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule